// File: doc/BRIEF.md
# I2C Master Byte-Transfer Engine

This block moves single bytes across an I2C bus on behalf of a master that has already started a transfer. One 8-bit data register is both the transmit and the receive shift register. Software starts each bus operation by accessing it. A write sends the register contents MSB first and then releases SDA for the slave's acknowledge bit. A read first drives the preset acknowledge bit for the previous byte, then releases SDA and shifts in eight new bits from the slave.

Bit timing comes from a one-cycle `tick` strobe. Each bit slot lasts two ticks: a low phase with SCL pulled low and a high phase with SCL released. The engine watches the SDA line for two faults. It flags lost arbitration when it releases SDA but sees the line low. It flags a bus error when SDA moves while SCL is high. Two interrupt flags report how each operation ended, and they are never set together. Between operations the engine holds SCL low and ignores everything except a new register access. START and STOP generation, baud-rate generation and the pad logic all sit outside this block.

Top module: `i2c_byte_engine`

## Requirements
- R1: When reset is released, `hold`=1, `scl_oe`=1, `sda_oe`=0, `rdata`=0x00, and all four flags are 0.
- R2: An access is accepted only while `hold`=1. While an operation runs (`hold`=0), `wr_en` and `rd_en` are ignored: data register, flags and bus timing are unchanged.
- R3: A bit slot is one tick with SCL pulled low (`scl_oe`=1), then one tick with SCL released (`scl_oe`=0). SDA is sampled when SCL is released, and `sda_oe` never changes while SCL stays released. Pulling a line low is encoded as its `_oe`=1.
- R4: An accepted write drives the eight data bits MSB first (bit 1 = released, bit 0 = pulled low), then releases SDA for a ninth acknowledge slot. It then sets `hold`=1, `wif`=1 and `rif`=0, whatever `ack_nack` is.
- R5: If SDA is released and sampled low in a write data slot, `arb_lost` is set. All later data slots release SDA. All nine slots are still clocked, and `wif` is set at the end.
- R6: An accepted read drives the acknowledge slot first (`ack_nack`=0 pulls SDA low, 1 releases it). It then releases SDA for eight slots, shifts the sampled bits into `rdata` MSB first, and sets `rif`=1, `wif`=0 and `hold`=1.
- R7: If a read's NACK slot is sampled low, `arb_lost` and `wif` are set, `rif` stays 0, and the engine returns to `hold` without clocking data slots.
- R8: If SDA at the end of a high phase differs from its value at the start of that phase, the operation stops at once. `bus_err`=1, `wif`=1 and `hold`=1.
- R9: `wif` and `rif` are never 1 together. An accepted access clears both and leaves `arb_lost` and `bus_err` unchanged.
- R10: `arb_lost` and `bus_err` stay set until `arb_clr` or `berr_clr` respectively. A new detection in the same cycle as the clear wins.
- R11: When `wr_en` and `rd_en` are both accepted in the same cycle, the write is performed.
- R12: After a write, `rdata` holds the eight values sampled on the wired-AND SDA line during the data slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Bus timing strobe, one phase per pulse |
| wr_en | input | 1 | Data register write strobe |
| rd_en | input | 1 | Data register read strobe |
| wdata | input | 8 | Byte written to the data register |
| ack_nack | input | 1 | Acknowledge action for reads: 0 ACK, 1 NACK |
| arb_clr | input | 1 | Clears the arbitration-lost flag |
| berr_clr | input | 1 | Clears the bus-error flag |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rdata | output | 8 | Data register contents |
| hold | output | 1 | Engine idle with SCL held low |
| wif | output | 1 | Write-side interrupt flag |
| rif | output | 1 | Read interrupt flag |
| arb_lost | output | 1 | Arbitration lost, sticky |
| bus_err | output | 1 | Bus error, sticky |

## Verification
The sensitive overlap is arbitration-loss detection falling in the same cycle as a software clear of the arbitration flag. The bench holds `arb_clr` high through a write in which the slave pulls one data slot low. The flag must appear for exactly one cycle and then drop. The per-cycle reference model fixes that cycle, and a directed check confirms the flag was seen. A second overlap, `wr_en` and `rd_en` arriving together, is judged by the first bit the engine drives and by the flag it raises at the end.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } op_e;
endpackage

// File: rtl/i2c_eng_seq.sv
module i2c_eng_seq
  import i2c_eng_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_wr,
  input  logic start_rd,
  input  logic nack_in,
  input  logic tick,
  input  logic sda_in,
  input  logic tx_msb,
  output logic busy,
  output logic scl_oe,
  output logic sda_oe,
  output logic shift_en,
  output logic shift_bit,
  output logic set_wif,
  output logic set_rif,
  output logic set_arb,
  output logic set_berr
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  op_e           op_q, op_d;
  logic          ph_q, ph_d;
  logic [CW-1:0] slot_q, slot_d;
  logic          smp_q, smp_d;
  logic          lost_q, lost_d;
  logic          nack_q, nack_d;

  logic drive_slot, want_one, end_bit, glitch, arb_hit, last;

  always_comb begin
    busy       = (op_q != OP_IDLE);
    last       = (slot_q == LAST);
    drive_slot = ((op_q == OP_WRITE) && (slot_q < LAST)) ||
                 ((op_q == OP_READ) && (slot_q == '0));
    want_one   = (op_q == OP_WRITE) ? (lost_q | tx_msb) : nack_q;
    end_bit    = busy & tick & ph_q;
    glitch     = end_bit & (sda_in != smp_q);
    arb_hit    = end_bit & ~glitch & drive_slot & want_one & ~smp_q;
    shift_en   = end_bit & ~glitch &
                 (((op_q == OP_WRITE) && !last) || ((op_q == OP_READ) && (slot_q != '0)));
    shift_bit  = smp_q;
    set_berr   = glitch;
    set_arb    = arb_hit;
    set_wif    = glitch | (arb_hit & (op_q == OP_READ)) |
                 (end_bit & ~glitch & last & (op_q == OP_WRITE));
    set_rif    = end_bit & ~glitch & last & (op_q == OP_READ);
    scl_oe     = ~busy | ~ph_q;
    sda_oe     = busy & drive_slot & ~want_one;
  end

  always_comb begin
    op_d   = op_q;
    ph_d   = ph_q;
    slot_d = slot_q;
    smp_d  = smp_q;
    lost_d = lost_q;
    nack_d = nack_q;
    if (start_wr) begin
      op_d   = OP_WRITE;
      ph_d   = 1'b0;
      slot_d = '0;
      lost_d = 1'b0;
    end else if (start_rd) begin
      op_d   = OP_READ;
      ph_d   = 1'b0;
      slot_d = '0;
      lost_d = 1'b0;
      nack_d = nack_in;
    end else if (busy && tick) begin
      if (!ph_q) begin
        ph_d  = 1'b1;
        smp_d = sda_in;
      end else begin
        ph_d = 1'b0;
        if (glitch || (arb_hit && (op_q == OP_READ)) || last) begin
          op_d = OP_IDLE;
        end else begin
          slot_d = slot_q + 1'b1;
          if (arb_hit) lost_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      ph_q   <= 1'b0;
      slot_q <= '0;
      smp_q  <= 1'b1;
      lost_q <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      op_q   <= op_d;
      ph_q   <= ph_d;
      slot_q <= slot_d;
      smp_q  <= smp_d;
      lost_q <= lost_d;
      nack_q <= nack_d;
    end
  end
endmodule

// File: rtl/i2c_eng_shreg.sv
module i2c_eng_shreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          shift,
  input  logic          in_bit,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_d;
  logic          en;

  always_comb begin
    en  = load | shift;
    q_d = load ? load_val : {q[DW-2:0], in_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_d;
  end
endmodule

// File: rtl/i2c_eng_flags.sv
module i2c_eng_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic access,
  input  logic set_wif,
  input  logic set_rif,
  input  logic set_arb,
  input  logic set_berr,
  input  logic arb_clr,
  input  logic berr_clr,
  output logic wif,
  output logic rif,
  output logic arb_lost,
  output logic bus_err
);
  logic wif_d, rif_d, arb_d, berr_d;

  always_comb begin
    wif_d  = access ? 1'b0 : (set_wif ? 1'b1 : (set_rif ? 1'b0 : wif));
    rif_d  = access ? 1'b0 : (set_rif ? 1'b1 : (set_wif ? 1'b0 : rif));
    arb_d  = set_arb  | (arb_lost & ~arb_clr);
    berr_d = set_berr | (bus_err & ~berr_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wif      <= 1'b0;
      rif      <= 1'b0;
      arb_lost <= 1'b0;
      bus_err  <= 1'b0;
    end else begin
      wif      <= wif_d;
      rif      <= rif_d;
      arb_lost <= arb_d;
      bus_err  <= berr_d;
    end
  end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  input  logic          ack_nack,
  input  logic          arb_clr,
  input  logic          berr_clr,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic [DW-1:0] rdata,
  output logic          hold,
  output logic          wif,
  output logic          rif,
  output logic          arb_lost,
  output logic          bus_err
);
  logic rst_meta, rst_sync_n;
  logic busy, start_wr, start_rd;
  logic shift_en, shift_bit;
  logic set_wif, set_rif, set_arb, set_berr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    hold     = ~busy;
    start_wr = wr_en & ~busy;
    start_rd = rd_en & ~busy & ~wr_en;
  end

  i2c_eng_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_wr  (start_wr),
    .start_rd  (start_rd),
    .nack_in   (ack_nack),
    .tick      (tick),
    .sda_in    (sda_in),
    .tx_msb    (rdata[DW-1]),
    .busy      (busy),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .shift_en  (shift_en),
    .shift_bit (shift_bit),
    .set_wif   (set_wif),
    .set_rif   (set_rif),
    .set_arb   (set_arb),
    .set_berr  (set_berr)
  );

  i2c_eng_shreg #(.DW(DW)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (start_wr),
    .load_val (wdata),
    .shift    (shift_en),
    .in_bit   (shift_bit),
    .q        (rdata)
  );

  i2c_eng_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .access   (start_wr | start_rd),
    .set_wif  (set_wif),
    .set_rif  (set_rif),
    .set_arb  (set_arb),
    .set_berr (set_berr),
    .arb_clr  (arb_clr),
    .berr_clr (berr_clr),
    .wif      (wif),
    .rif      (rif),
    .arb_lost (arb_lost),
    .bus_err  (bus_err)
  );
endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr_en,
  input logic          rd_en,
  input logic          arb_clr,
  input logic          berr_clr,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic [DW-1:0] rdata,
  input logic          hold,
  input logic          wif,
  input logic          rif,
  input logic          arb_lost,
  input logic          bus_err
);
  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wif && rif));

  p_access_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && (wr_en || rd_en)) |=> (!wif && !rif && !hold));

  p_busy_ignores_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && wr_en && !tick) |=> $stable(rdata));

  p_sda_still_while_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_oe |=> (scl_oe || $stable(sda_oe)));

  p_arb_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !arb_clr) |=> arb_lost);

  p_berr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !berr_clr) |=> bus_err);

  p_berr_aborts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_err) |-> (hold && wif && !rif));

  p_idle_holds_scl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (scl_oe && !sda_oe));
endmodule

bind i2c_byte_engine i2c_byte_engine_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .arb_clr  (arb_clr),
  .berr_clr (berr_clr),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe),
  .rdata    (rdata),
  .hold     (hold),
  .wif      (wif),
  .rif      (rif),
  .arb_lost (arb_lost),
  .bus_err  (bus_err)
);

// File: tb/i2c_byte_engine_tb.sv
module i2c_byte_engine_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       ack_nack = 1'b0;
  logic       arb_clr = 1'b0;
  logic       berr_clr = 1'b0;
  logic       slave_sda = 1'b1;
  logic       glitch = 1'b0;
  logic       sda_line;
  logic       scl_oe, sda_oe, hold, wif, rif, arb_lost, bus_err;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign sda_line = ~sda_oe & slave_sda & ~glitch;

  i2c_byte_engine u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .ack_nack(ack_nack), .arb_clr(arb_clr), .berr_clr(berr_clr),
    .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe), .rdata(rdata),
    .hold(hold), .wif(wif), .rif(rif), .arb_lost(arb_lost), .bus_err(bus_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, advanced at every rising edge
  int       m_op = 0;   // 0 idle, 1 write, 2 read
  int       m_slot = 0;
  bit       m_high = 0, m_smp = 1, m_lost = 0, m_nack = 0;
  bit [7:0] m_sr = 0;
  bit       m_wif = 0, m_rif = 0, m_arb = 0, m_berr = 0;

  function automatic bit m_drives();
    return (m_op == 1 && m_slot < 8) || (m_op == 2 && m_slot == 0);
  endfunction
  function automatic bit m_one();
    return (m_op == 1) ? (m_lost || m_sr[7]) : m_nack;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_op = 0; m_slot = 0; m_high = 0; m_smp = 1; m_lost = 0; m_nack = 0;
      m_sr = 0; m_wif = 0; m_rif = 0; m_arb = 0; m_berr = 0;
    end else begin
      automatic bit busy = (m_op != 0);
      automatic bit drv = m_drives();
      automatic bit one = m_one();
      automatic bit line = sda_line;
      if (arb_clr) m_arb = 0;
      if (berr_clr) m_berr = 0;
      if (wr_en && !busy) begin
        m_op = 1; m_slot = 0; m_high = 0; m_lost = 0; m_sr = wdata; m_wif = 0; m_rif = 0;
      end else if (rd_en && !busy) begin
        m_op = 2; m_slot = 0; m_high = 0; m_lost = 0; m_nack = ack_nack; m_wif = 0; m_rif = 0;
      end else if (busy && tick) begin
        if (!m_high) begin
          m_high = 1; m_smp = line;
        end else if (line != m_smp) begin
          m_berr = 1; m_wif = 1; m_rif = 0; m_op = 0; m_high = 0;
        end else begin
          m_high = 0;
          if (drv && one && !m_smp) begin
            m_arb = 1;
            if (m_op == 1) m_lost = 1;
            else begin m_op = 0; m_wif = 1; m_rif = 0; end
          end
          if (m_op != 0) begin
            if ((m_op == 1 && m_slot < 8) || (m_op == 2 && m_slot != 0))
              m_sr = {m_sr[6:0], m_smp};
            if (m_slot == 8) begin
              if (m_op == 1) begin m_wif = 1; m_rif = 0; end
              else begin m_rif = 1; m_wif = 0; end
              m_op = 0;
            end else m_slot++;
          end
        end
      end
    end
  end

  // Slave, bit capture and per-cycle comparison, all away from the active edge
  bit   pat[0:8];
  int   idx = 0;
  int   inject_slot = -1;
  bit   glitch_done = 0;
  bit   scl_prev = 1;
  bit   seen_arb = 0;
  bit   cap[$];
  int   tick_div = 0;

  always @(negedge clk) begin
    cycles++;
    tick_div = (tick_div + 1) % 4;
    tick <= (tick_div == 0);
    if (rst_n) begin
      if (!scl_oe && scl_prev) cap.push_back(sda_line);
      if (scl_oe && !scl_prev) begin
        idx++;
        slave_sda <= (idx < 9) ? pat[idx] : 1'b1;
      end
      if (!scl_oe && idx == inject_slot && !glitch_done) begin
        glitch <= 1'b1;
        glitch_done = 1;
      end
      if (arb_lost) seen_arb = 1;
      if (!finished) begin
        check({scl_oe, sda_oe, hold} == {!(m_op != 0) || !m_high, (m_op != 0) && m_drives() && !m_one(), m_op == 0},
              "R3 bus pins vs model", {scl_oe, sda_oe, hold},
              {!(m_op != 0) || !m_high, (m_op != 0) && m_drives() && !m_one(), m_op == 0});
        check({wif, rif, arb_lost, bus_err} == {m_wif, m_rif, m_arb, m_berr},
              "R9 flags vs model", {wif, rif, arb_lost, bus_err}, {m_wif, m_rif, m_arb, m_berr});
        check(rdata == m_sr, "R12 data register vs model", rdata, m_sr);
      end
      scl_prev = scl_oe;
    end
  end

  task automatic set_pat(input bit [8:0] p);
    for (int i = 0; i < 9; i++) pat[i] = p[8-i];
    idx = 0;
    slave_sda <= p[8];
    cap.delete();
    glitch_done = 0;
    seen_arb = 0;
  endtask

  task automatic wait_hold();
    int n = 0;
    @(negedge clk);
    while (!hold && n < 5000) begin @(negedge clk); n++; end
    glitch <= 1'b0;
    inject_slot = -1;
    repeat (2) @(negedge clk);
  endtask

  task automatic start(input bit w, input bit r, input bit [7:0] d, input bit nk);
    @(negedge clk);
    wdata <= d; ack_nack <= nk; wr_en <= w; rd_en <= r;
    @(negedge clk);
    wr_en <= 1'b0; rd_en <= 1'b0;
  endtask

  function automatic bit [7:0] cap_byte(input int first);
    bit [7:0] v = 0;
    for (int i = 0; i < 8; i++) v = {v[6:0], cap[first+i]};
    return v;
  endfunction

  initial begin : watchdog
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(hold && scl_oe && !sda_oe, "R1 idle pins", {hold, scl_oe, sda_oe}, 3'b110);
    check(rdata == 8'h00 && !wif && !rif && !arb_lost && !bus_err, "R1 register and flags",
          {rdata, wif, rif, arb_lost, bus_err}, 0);

    // R4 plain write with ACK; R12 read-back; R2 accesses during the byte
    set_pat(9'b1_1111_1110);
    start(1, 0, 8'hA5, 1);
    repeat (10) @(negedge clk);
    wdata <= 8'h00; wr_en <= 1'b1; rd_en <= 1'b1;
    @(negedge clk);
    wr_en <= 1'b0; rd_en <= 1'b0;
    wait_hold();
    check(cap.size() == 9, "R4 nine slots clocked", cap.size(), 9);
    check(cap_byte(0) == 8'hA5, "R4 MSB-first bits on SDA", cap_byte(0), 8'hA5);
    check(cap[8] == 1'b0, "R4 ack slot sampled", cap[8], 0);
    check(wif && !rif, "R4 write flag", {wif, rif}, 2'b10);
    check(rdata == 8'hA5, "R2 access while busy ignored", rdata, 8'hA5);

    // R6 read with ACK
    set_pat(9'b1_0011_1100);
    start(0, 1, 8'h00, 0);
    @(negedge clk);
    check(!wif && !rif, "R9 read access clears flags", {wif, rif}, 0);
    wait_hold();
    check(cap[0] == 1'b0, "R6 ACK driven low", cap[0], 0);
    check(rdata == 8'h3C, "R6 received byte", rdata, 8'h3C);
    check(rif && !wif, "R6 read flag", {wif, rif}, 2'b01);

    // R6 read with NACK
    set_pat(9'b1_1100_0011);
    start(0, 1, 8'h00, 1);
    wait_hold();
    check(cap[0] == 1'b1, "R6 NACK released", cap[0], 1);
    check(rdata == 8'hC3, "R6 received byte NACK", rdata, 8'hC3);

    // R5 arbitration loss in slot 2 of a write
    set_pat(9'b1_1011_1110);
    start(1, 0, 8'hFF, 0);
    wait_hold();
    check(arb_lost, "R5 arbitration flag", arb_lost, 1);
    check(cap.size() == 9, "R5 all slots clocked", cap.size(), 9);
    check(rdata == 8'hDF, "R5 bus value shifted in", rdata, 8'hDF);
    check(wif && !rif, "R5 write flag after loss", {wif, rif}, 2'b10);

    // R10 sticky across a new access; R9 access leaves it alone
    set_pat(9'b1_1111_1110);
    start(1, 0, 8'h5A, 0);
    check(arb_lost && !wif, "R9 access keeps arbitration flag", {arb_lost, wif}, 2'b10);
    wait_hold();
    check(arb_lost, "R10 arbitration flag sticky", arb_lost, 1);
    @(negedge clk); arb_clr <= 1'b1; @(negedge clk); arb_clr <= 1'b0;
    @(negedge clk);
    check(!arb_lost, "R10 arbitration flag cleared", arb_lost, 0);

    // R10 detection coinciding with a held clear
    set_pat(9'b1_1110_1110);
    arb_clr <= 1'b1;
    start(1, 0, 8'hFF, 0);
    wait_hold();
    arb_clr <= 1'b0;
    check(seen_arb, "R10 set wins over clear", seen_arb, 1);
    check(!arb_lost, "R10 clear after detection", arb_lost, 0);

    // R7 arbitration loss on the NACK slot
    set_pat(9'b0_1111_1111);
    start(0, 1, 8'h00, 1);
    wait_hold();
    check(cap.size() == 1, "R7 no data slots", cap.size(), 1);
    check(arb_lost && wif && !rif, "R7 flags", {arb_lost, wif, rif}, 3'b110);
    @(negedge clk); arb_clr <= 1'b1; @(negedge clk); arb_clr <= 1'b0;

    // R8 bus error injected in slot 3
    set_pat(9'b1_1111_1111);
    inject_slot = 3;
    start(1, 0, 8'hFF, 0);
    wait_hold();
    check(cap.size() == 4, "R8 aborted after slot", cap.size(), 4);
    check(bus_err && wif && !rif, "R8 flags", {bus_err, wif, rif}, 3'b110);
    @(negedge clk); berr_clr <= 1'b1; @(negedge clk); berr_clr <= 1'b0;
    @(negedge clk);
    check(!bus_err, "R10 bus error cleared", bus_err, 0);

    // R11 simultaneous write and read strobes
    set_pat(9'b1_1111_1110);
    start(1, 1, 8'hF0, 0);
    wait_hold();
    check(cap[0] == 1'b1 && cap.size() == 9, "R11 write chosen", cap[0], 1);
    check(wif && !rif && rdata == 8'hF0, "R11 write outcome", {wif, rif, rdata}, {2'b10, 8'hF0});

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule